// File: doc/BRIEF.md
# Grouped Four-Level Priority Interrupt Controller

This block collects 24 maskable interrupt requests and one nonmaskable request for a small 8-bit CPU core. It selects one winner per clock and offers it to the CPU as a 5-bit vector together with a request line. The maskable sources are arranged in six groups of four. Group `g` holds sources `g`, `g+6`, `g+12` and `g+18`. Each group gets one of four priority levels, and all sources in a group share that level. Software controls per-source enables, a global enable and the group levels through a small byte-wide register port.

The CPU takes an offered interrupt by pulsing `cpu_ack` while `cpu_irq` is high. It signals the end of a handler by pulsing `cpu_reti`. The block keeps an in-service bit for each level and one for the nonmaskable source. A request is offered only when its rank is strictly above the highest level currently in service, so handlers nest by level.

Sources 0 and 1 are fed from two asynchronous pins. Each pin passes through a two-flop synchronizer and is then decoded as a level or as an edge, with selectable polarity. Sources 2 to 23 come in as single-cycle pulses from on-chip logic and are held pending until they are serviced.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `cpu_irq` is low and every register reads 0. Address 7 also reads 0.
- R2: When the global enable (bit 7 of register 0) is 0, no maskable source is offered. When it is 1, a source is offered only if its own enable bit is set. Source `s` has its enable at flat bit `s` of registers 0..3 (register `r` holds flat bits 8r..8r+7) for s<7, and at flat bit `s+1` for s≥7.
- R3: The level of group `g` is `{reg5[g], reg4[g]}`, from 0 (lowest) to 3 (highest).
- R4: When requests of different levels are pending together, the higher level is offered first.
- R5: When requests share a level, the lower group number wins. Within a group the lower source index wins. The vector is the source index 0..23, or 31 for the nonmaskable source.
- R6: The nonmaskable request is offered regardless of any enable bit. It preempts any maskable handler and is offered with vector 31.
- R7: An acknowledge marks the winner's level in service. A return clears the highest level in service. A new request is offered only if its level is strictly above the highest level in service.
- R8: In level mode, a pin requests only while it sits at its active level, with nothing latched. Pin requests appear after two synchronizer flops. Register 6 holds the pin modes: bit `e` selects edge mode for pin `e`, and bit `4+e` selects active-high/rising. Both bits are 0 after reset, which gives active-low level mode.
- R9: In edge mode, only the selected edge sets a pending flag, and an acknowledge of that source clears the flag.
- R10: A one-cycle pulse on `src_req[s]` stays pending until source `s` is acknowledged.
- R11: A pulse sampled at clock edge k makes `cpu_irq` high after edge k+1.
- R12: Registers 0..6 read back the values written to them. Registers 4 and 5 keep only bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| src_req | input | 22 | Pulse requests for sources 2..23 |
| ext_pin | input | 2 | Asynchronous pins feeding sources 0 and 1 |
| nmi_req | input | 1 | Nonmaskable request pulse |
| cpu_irq | output | 1 | Interrupt offered to the CPU |
| cpu_vec | output | 5 | Vector of the offered interrupt |
| cpu_ack | input | 1 | CPU takes the offered interrupt |
| cpu_reti | input | 1 | CPU returns from the current handler |

## Verification
The hardest case to reach is a request that is pending but held back because a handler of the same or higher level is in service, and that must then surface once the CPU returns. The stimulus builds a nested stack: it takes a level-0 handler, preempts it with a level-1 source, and then raises a second level-1 request. It checks that the second request stays silent until the return, after which it is offered. A similar path shows the nonmaskable source breaking into a level-3 handler. A further path shows a held-low level pin being offered again after its return.

// File: rtl/pic_pkg.sv
package pic_pkg;
   localparam int PIC_REG_AW = 3;
   localparam int PIC_DW     = 8;
   localparam int PIC_LVL_W  = 2;
   localparam int PIC_LEVELS = 1 << PIC_LVL_W;

   typedef enum logic [PIC_REG_AW-1:0] {
      RA_EN0   = 3'd0,
      RA_EN1   = 3'd1,
      RA_EN2   = 3'd2,
      RA_EN3   = 3'd3,
      RA_LVLLO = 3'd4,
      RA_LVLHI = 3'd5,
      RA_XCFG  = 3'd6
   } pic_reg_e;
endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta_q;
   logic [W-1:0] out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         out_q  <= '0;
      end else begin
         meta_q <= d;
         out_q  <= meta_q;
      end
   end

   assign q = out_q;
endmodule

// File: rtl/pic_ext_detect.sv
module pic_ext_detect #(
   parameter int NUM_EXT = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EXT-1:0] pin,
   input  logic [NUM_EXT-1:0] edge_mode,
   input  logic [NUM_EXT-1:0] act_high,
   input  logic [NUM_EXT-1:0] clr,
   output logic [NUM_EXT-1:0] req
);
   logic [NUM_EXT-1:0] pin_s;
   logic [NUM_EXT-1:0] prev_q;

   pic_sync #(.W(NUM_EXT)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin),
      .q     (pin_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pin_s;
   end

   for (genvar e = 0; e < NUM_EXT; e++) begin : g_ch
      logic lvl_on;
      logic hit;
      logic pend_q;

      assign lvl_on = act_high[e] ? pin_s[e] : ~pin_s[e];
      assign hit    = act_high[e] ? (pin_s[e] & ~prev_q[e])
                                  : (~pin_s[e] & prev_q[e]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              pend_q <= 1'b0;
         else if (!edge_mode[e])  pend_q <= 1'b0;
         else if (hit)            pend_q <= 1'b1;
         else if (clr[e])         pend_q <= 1'b0;
      end

      assign req[e] = edge_mode[e] ? pend_q : lvl_on;
   end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
   parameter int NUM_GROUPS = 6,
   parameter int GROUP_SIZE = 4,
   parameter int LVL_W      = 2,
   parameter int VEC_W      = 5,
   parameter int RANK_W     = 3,
   localparam int NUM_SRC   = NUM_GROUPS * GROUP_SIZE,
   localparam int LEVELS    = 1 << LVL_W
) (
   input  logic [NUM_SRC-1:0]          act,
   input  logic [NUM_GROUPS*LVL_W-1:0] grp_lvl,
   input  logic                        nmi_act,
   output logic                        win_v,
   output logic [VEC_W-1:0]            win_idx,
   output logic [RANK_W-1:0]           win_rank
);
   localparam logic [VEC_W-1:0] NMI_VEC = '1;

   always_comb begin
      win_v    = 1'b0;
      win_idx  = '0;
      win_rank = '0;
      if (nmi_act) begin
         win_v    = 1'b1;
         win_idx  = NMI_VEC;
         win_rank = RANK_W'(LEVELS + 1);
      end else begin
         for (int i = 0; i < LEVELS; i++) begin
            for (int g = 0; g < NUM_GROUPS; g++) begin
               for (int k = 0; k < GROUP_SIZE; k++) begin
                  if (!win_v && act[g + NUM_GROUPS*k] &&
                      grp_lvl[g*LVL_W +: LVL_W] == LVL_W'(LEVELS-1-i)) begin
                     win_v    = 1'b1;
                     win_idx  = VEC_W'(g + NUM_GROUPS*k);
                     win_rank = RANK_W'(LEVELS - i);
                  end
               end
            end
         end
      end
   end
endmodule

// File: rtl/pic_isr_stack.sv
module pic_isr_stack #(
   parameter int LEVELS = 4,
   parameter int RANK_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [RANK_W-1:0] push_rank,
   input  logic              pop,
   output logic [RANK_W-1:0] run_rank
);
   logic [LEVELS:0] isr_q;
   logic [LEVELS:0] isr_d;

   always_comb begin
      run_rank = '0;
      for (int i = 0; i <= LEVELS; i++)
         if (isr_q[i]) run_rank = RANK_W'(i + 1);
   end

   always_comb begin
      isr_d = isr_q;
      if (pop && run_rank != '0) isr_d[run_rank - 1'b1] = 1'b0;
      if (push && push_rank != '0) isr_d[push_rank - 1'b1] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) isr_q <= '0;
      else        isr_q <= isr_d;
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import pic_pkg::*;
#(
   parameter int NUM_GROUPS = 6,
   parameter int GROUP_SIZE = 4,
   parameter int NUM_EXT    = 2,
   parameter int EN_REGS    = 4,
   parameter int VEC_W      = 5,
   localparam int NUM_SRC   = NUM_GROUPS * GROUP_SIZE,
   localparam int ENW       = EN_REGS * PIC_DW,
   localparam int GLB_BIT   = 7,
   localparam int RANK_W    = $clog2(PIC_LEVELS + 2)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      reg_we,
   input  logic [PIC_REG_AW-1:0]     reg_addr,
   input  logic [PIC_DW-1:0]         reg_wdata,
   output logic [PIC_DW-1:0]         reg_rdata,
   input  logic [NUM_SRC-1:NUM_EXT]  src_req,
   input  logic [NUM_EXT-1:0]        ext_pin,
   input  logic                      nmi_req,
   output logic                      cpu_irq,
   output logic [VEC_W-1:0]          cpu_vec,
   input  logic                      cpu_ack,
   input  logic                      cpu_reti
);
   localparam logic [VEC_W-1:0] NMI_VEC = '1;

   if (NUM_SRC + 1 > ENW) begin : g_bad_en
      $error("enable registers too narrow for source count");
   end
   if (NUM_GROUPS > PIC_DW) begin : g_bad_grp
      $error("group count exceeds priority register width");
   end
   if (NUM_EXT > PIC_DW/2 || NUM_EXT < 1) begin : g_bad_ext
      $error("pin count must fit half a config register");
   end
   if ((1 << VEC_W) <= NUM_SRC) begin : g_bad_vec
      $error("vector width leaves no code for the nonmaskable source");
   end

   logic [ENW-1:0]        en_flat_q;
   logic [NUM_GROUPS-1:0] lvl_lo_q, lvl_hi_q;
   logic [PIC_DW-1:0]     xcfg_q;
   logic                  glb_en;
   logic [NUM_SRC-1:0]    en_src, req_all, act;
   logic [NUM_SRC-1:0]    pend_q;
   logic                  nmi_pend_q;
   logic [NUM_EXT-1:0]    ext_req, ext_clr;
   logic [NUM_GROUPS*PIC_LVL_W-1:0] grp_lvl;
   logic                  arb_v;
   logic [VEC_W-1:0]      arb_idx;
   logic [RANK_W-1:0]     arb_rank;
   logic                  win_v_q;
   logic [VEC_W-1:0]      win_idx_q;
   logic [RANK_W-1:0]     win_rank_q;
   logic [RANK_W-1:0]     run_rank;
   logic                  ack_fire;

   // register port
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_flat_q <= '0;
         lvl_lo_q  <= '0;
         lvl_hi_q  <= '0;
         xcfg_q    <= '0;
      end else if (reg_we) begin
         if (int'(reg_addr) < EN_REGS)
            en_flat_q[int'(reg_addr)*PIC_DW +: PIC_DW] <= reg_wdata;
         else if (reg_addr == RA_LVLLO)
            lvl_lo_q <= reg_wdata[NUM_GROUPS-1:0];
         else if (reg_addr == RA_LVLHI)
            lvl_hi_q <= reg_wdata[NUM_GROUPS-1:0];
         else if (reg_addr == RA_XCFG)
            xcfg_q <= reg_wdata;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (int'(reg_addr) < EN_REGS)
         reg_rdata = en_flat_q[int'(reg_addr)*PIC_DW +: PIC_DW];
      else if (reg_addr == RA_LVLLO)
         reg_rdata[NUM_GROUPS-1:0] = lvl_lo_q;
      else if (reg_addr == RA_LVLHI)
         reg_rdata[NUM_GROUPS-1:0] = lvl_hi_q;
      else if (reg_addr == RA_XCFG)
         reg_rdata = xcfg_q;
   end

   assign glb_en = en_flat_q[GLB_BIT];

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_en
      if (s < GLB_BIT) begin : g_lo
         assign en_src[s] = en_flat_q[s];
      end else begin : g_hi
         assign en_src[s] = en_flat_q[s + 1];
      end
   end

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_lvl
      assign grp_lvl[g*PIC_LVL_W +: PIC_LVL_W] = {lvl_hi_q[g], lvl_lo_q[g]};
   end

   assign ack_fire = cpu_ack & cpu_irq;

   // pin sources
   for (genvar e = 0; e < NUM_EXT; e++) begin : g_xclr
      assign ext_clr[e] = ack_fire && (win_idx_q == VEC_W'(e));
   end

   pic_ext_detect #(.NUM_EXT(NUM_EXT)) u_ext (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin       (ext_pin),
      .edge_mode (xcfg_q[NUM_EXT-1:0]),
      .act_high  (xcfg_q[4 +: NUM_EXT]),
      .clr       (ext_clr),
      .req       (ext_req)
   );

   // pending latches for on-chip sources
   for (genvar s = 0; s < NUM_SRC; s++) begin : g_pend
      if (s < NUM_EXT) begin : g_pin
         assign pend_q[s]  = 1'b0;
         assign req_all[s] = ext_req[s];
      end else begin : g_int
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pend_q[s] <= 1'b0;
            else if (src_req[s])
               pend_q[s] <= 1'b1;
            else if (ack_fire && win_idx_q == VEC_W'(s))
               pend_q[s] <= 1'b0;
         end
         assign req_all[s] = pend_q[s];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                nmi_pend_q <= 1'b0;
      else if (nmi_req)                          nmi_pend_q <= 1'b1;
      else if (ack_fire && win_idx_q == NMI_VEC) nmi_pend_q <= 1'b0;
   end

   assign act = req_all & en_src & {NUM_SRC{glb_en}};

   pic_arbiter #(
      .NUM_GROUPS (NUM_GROUPS),
      .GROUP_SIZE (GROUP_SIZE),
      .LVL_W      (PIC_LVL_W),
      .VEC_W      (VEC_W),
      .RANK_W     (RANK_W)
   ) u_arb (
      .act      (act),
      .grp_lvl  (grp_lvl),
      .nmi_act  (nmi_pend_q),
      .win_v    (arb_v),
      .win_idx  (arb_idx),
      .win_rank (arb_rank)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_v_q    <= 1'b0;
         win_idx_q  <= '0;
         win_rank_q <= '0;
      end else begin
         win_v_q    <= arb_v;
         win_idx_q  <= arb_idx;
         win_rank_q <= arb_rank;
      end
   end

   pic_isr_stack #(.LEVELS(PIC_LEVELS), .RANK_W(RANK_W)) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (ack_fire),
      .push_rank (win_rank_q),
      .pop       (cpu_reti),
      .run_rank  (run_rank)
   );

   assign cpu_irq = win_v_q && (win_rank_q > run_rank);
   assign cpu_vec = win_idx_q;
endmodule

// File: rtl/prio_irq_ctrl_sva.sv
module prio_irq_ctrl_sva #(
   parameter int VEC_W  = 5,
   parameter int RANK_W = 3,
   parameter int NUM_SRC = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_irq,
   input logic              cpu_ack,
   input logic              cpu_reti,
   input logic [VEC_W-1:0]  cpu_vec,
   input logic              glb_en,
   input logic [RANK_W-1:0] run_rank
);
   localparam logic [VEC_W-1:0] NMI_VEC = '1;

   assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !cpu_irq);

   assert_global_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_irq && cpu_vec != NMI_VEC) |-> $past(glb_en));

   assert_vec_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq |-> (int'(cpu_vec) < NUM_SRC || cpu_vec == NMI_VEC));

   assert_ack_raises_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack && cpu_irq) |=> run_rank > $past(run_rank));

   assert_return_lowers_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_reti && !(cpu_ack && cpu_irq) && run_rank != '0) |=> run_rank < $past(run_rank));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_sva #(.VEC_W(VEC_W), .RANK_W(RANK_W), .NUM_SRC(NUM_SRC)) u_sva (
   .clk      (clk),
   .rst_n    (rst_n),
   .cpu_irq  (cpu_irq),
   .cpu_ack  (cpu_ack),
   .cpu_reti (cpu_reti),
   .cpu_vec  (cpu_vec),
   .glb_en   (glb_en),
   .run_rank (run_rank)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [23:2] src_req = '0;
   logic [1:0]  ext_pin = 2'b11;
   logic        nmi_req = 1'b0;
   logic        cpu_irq;
   logic [4:0]  cpu_vec;
   logic        cpu_ack = 1'b0;
   logic        cpu_reti = 1'b0;

   always #10 clk = ~clk;

   prio_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_req(src_req),
      .ext_pin(ext_pin), .nmi_req(nmi_req), .cpu_irq(cpu_irq),
      .cpu_vec(cpu_vec), .cpu_ack(cpu_ack), .cpu_reti(cpu_reti)
   );

   typedef struct {
      logic [4:0] vec;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_we    = 1'b1;
      tick();
      reg_we    = 1'b0;
   endtask

   task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
      reg_addr = a;
      #2;
      chk(reg_rdata == exp, tag, reg_rdata, exp);
   endtask

   task automatic pulse(input logic [23:2] m);
      src_req = m;
      tick();
      src_req = '0;
   endtask

   task automatic pulse_nmi();
      nmi_req = 1'b1;
      tick();
      nmi_req = 1'b0;
   endtask

   task automatic wait_irq(input string tag);
      for (int i = 0; i < 20 && !cpu_irq; i++) tick();
      chk(cpu_irq == 1'b1, tag, cpu_irq, 1);
   endtask

   task automatic quiet(input int n, input string tag);
      repeat (n) tick();
      chk(cpu_irq == 1'b0, tag, cpu_irq, 0);
   endtask

   // driver side of the scoreboard: expected vector for this acknowledge
   task automatic take(input logic [4:0] v, input string tag);
      exp_q.push_back('{vec: v, tag: tag});
      cpu_ack = 1'b1;
      tick();
      cpu_ack = 1'b0;
   endtask

   task automatic reti();
      cpu_reti = 1'b1;
      tick();
      cpu_reti = 1'b0;
   endtask

   // monitor side: every accepted interrupt is compared against the queue
   always @(negedge clk) begin : mon
      exp_t e;
      if (rst_n && cpu_ack && cpu_irq) begin
         n_cmp++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL unexpected accept: actual vec %0d expected none", cpu_vec);
         end else begin
            e = exp_q.pop_front();
            if (cpu_vec !== e.vec) begin
               n_bad++;
               $display("FAIL %s: actual vec %0d expected %0d", e.tag, cpu_vec, e.vec);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (4) tick();
      rst_n = 1'b1;
      tick();

      // R1: reset state
      chk(cpu_irq == 1'b0, "R1 irq idle", cpu_irq, 0);
      for (int a = 0; a < 8; a++) rd_chk(3'(a), 8'h00, "R1 reset readback");

      // R2: global enable off masks an individually enabled source
      wr(3'd0, 8'h7F);
      pulse(22'(1) << (3-2));
      quiet(4, "R2 global off");
      wr(3'd0, 8'hFF);
      wait_irq("R2 global on");
      take(5'd3, "R2 src3");
      reti();

      // R2: individual enable (src 9 -> flat bit 10 -> reg1 bit2)
      pulse(22'(1) << (9-2));
      quiet(4, "R2 src9 disabled");
      wr(3'd1, 8'h04);
      wait_irq("R2 src9 enabled");
      take(5'd9, "R2 src9");
      reti();
      wr(3'd1, 8'hFF);
      wr(3'd2, 8'hFF);
      wr(3'd3, 8'hFF);

      // R10 / R11: latency of a pulse, held pending
      pulse(22'(1) << (10-2));
      chk(cpu_irq == 1'b0, "R11 not yet", cpu_irq, 0);
      tick();
      chk(cpu_irq == 1'b1, "R11 one edge later", cpu_irq, 1);
      repeat (5) tick();
      chk(cpu_irq == 1'b1, "R10 still pending", cpu_irq, 1);
      take(5'd10, "R10 src10");
      reti();
      quiet(3, "R10 cleared by ack");

      // R4 / R7: group2 at level 3 beats group4 at level 0
      wr(3'd4, 8'h04);
      wr(3'd5, 8'h04);
      pulse((22'(1) << (4-2)) | (22'(1) << (14-2)));
      wait_irq("R4 wait");
      take(5'd14, "R4 higher level first");
      quiet(4, "R7 lower level blocked");
      reti();
      wait_irq("R4 lower after return");
      take(5'd4, "R4 src4");
      reti();

      // R3: level 2 from high register beats level 1 from low register
      wr(3'd4, 8'h01);
      wr(3'd5, 8'h10);
      pulse((22'(1) << (6-2)) | (22'(1) << (10-2)));
      wait_irq("R3 wait");
      take(5'd10, "R3 group4 level2");
      reti();
      wait_irq("R3 wait2");
      take(5'd6, "R3 group0 level1");
      reti();
      wr(3'd4, 8'h00);
      wr(3'd5, 8'h00);

      // R5: same level order
      pulse((22'(1) << (7-2)) | (22'(1) << (12-2)) | (22'(1) << (19-2)));
      wait_irq("R5 wait a");
      take(5'd12, "R5 group0 first");
      reti();
      wait_irq("R5 wait b");
      take(5'd7, "R5 group1 low index");
      reti();
      wait_irq("R5 wait c");
      take(5'd19, "R5 group1 high index");
      reti();

      // R7: nesting, strictly higher only
      wr(3'd4, 8'h08);
      pulse(22'(1) << (8-2));
      wait_irq("R7 wait base");
      take(5'd8, "R7 level0 handler");
      pulse(22'(1) << (21-2));
      wait_irq("R7 preempt");
      take(5'd21, "R7 level1 preempts");
      pulse(22'(1) << (3-2));
      quiet(4, "R7 same level held");
      reti();
      wait_irq("R7 released");
      take(5'd3, "R7 same level after return");
      reti();
      reti();
      quiet(3, "R7 stack empty");
      wr(3'd4, 8'h00);

      // R6: nonmaskable ignores enables and preempts level 3
      wr(3'd0, 8'h00);
      pulse_nmi();
      wait_irq("R6 masked nmi");
      take(5'd31, "R6 nmi vector");
      reti();
      wr(3'd0, 8'hFF);
      wr(3'd4, 8'h3F);
      wr(3'd5, 8'h3F);
      pulse(22'(1) << (5-2));
      wait_irq("R6 wait src5");
      take(5'd5, "R6 level3 handler");
      pulse_nmi();
      wait_irq("R6 preempt");
      take(5'd31, "R6 nmi over level3");
      reti();
      reti();
      wr(3'd4, 8'h00);
      wr(3'd5, 8'h00);

      // R8: pin 0 active-low level, not latched
      ext_pin[0] = 1'b0;
      wait_irq("R8 level seen");
      take(5'd0, "R8 pin0");
      reti();
      wait_irq("R8 re-request while held");
      take(5'd0, "R8 pin0 again");
      ext_pin[0] = 1'b1;
      repeat (4) tick();
      reti();
      quiet(4, "R8 released pin not latched");

      // R9: pin 1 rising-edge mode (cfg bit1 edge, bit5 active high)
      wr(3'd6, 8'h22);
      ext_pin[1] = 1'b0;
      quiet(6, "R9 falling edge ignored");
      ext_pin[1] = 1'b1;
      wait_irq("R9 rising edge");
      take(5'd1, "R9 pin1");
      reti();
      quiet(6, "R9 flag cleared by ack");

      // R12: readback
      wr(3'd4, 8'hD5);
      rd_chk(3'd4, 8'h15, "R12 level low reg");
      rd_chk(3'd6, 8'h22, "R12 pin config");
      rd_chk(3'd2, 8'hFF, "R12 enable reg");

      tick();
      while (exp_q.size() != 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_cmp++;
         n_bad++;
         $display("FAIL %s: actual none expected vec %0d", e.tag, e.vec);
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule